// File: doc/BRIEF.md
# Circular Stream Address Generator

This block produces the word addresses for a streamed transfer between memory and one of eight data FIFOs. A stream is described by a window (lowest and highest word address, both inclusive), a start pointer inside that window, a signed stride and a transfer count, plus a FIFO selector and a direction bit. Once loaded, the block offers one address at a time on a valid/ready port toward memory. Each accepted address advances the pointer by the stride, and the pointer is folded back into the window modulo its size.

The stride is first reduced modulo the window size by a short serial division. After that, each step needs only one add and one conditional subtract. Because of this reduction, strides larger than the window and negative strides behave as true modular steps. When the last transfer has been accepted, the block raises a one-cycle completion pulse and becomes ready for the next stream. The eight FIFOs and the memory are outside the block. The FIFO number and the direction simply travel with every address.

Top module: `ring_stream_agen`

## Requirements
- R1: A stream description is taken only while `cfg_ready` is high, which is only when no stream is active. A `cfg_valid` held during a stream changes neither `cfg_ready` nor the address sequence.
- R2: The first address offered after a load equals the start pointer.
- R3: Exactly `cfg_count` addresses are accepted. A count of one gives a single access. `done` is high for exactly one cycle, in the cycle after the last acceptance.
- R4: With window size N = upper − lower + 1, each next address is lower + ((address − lower + stride) mod N). This applies to strides larger than N and to a zero stride, and every offered address lies in [lower, upper].
- R5: A negative stride (two's complement) that steps below lower re-enters the window from the upper end by the same modular rule.
- R6: A count of zero raises `done` in the cycle after the load and offers no address.
- R7: `mem_fifo` (0 to 7) and `mem_write` (1 = memory write from a FIFO, 0 = memory read into a FIFO) equal the loaded values for every address of the stream.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_fifo` and `mem_write` hold.
- R9: After synchronous reset, `cfg_ready` is 1, and `mem_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Stream description offered |
| cfg_ready | output | 1 | Block idle, description accepted this cycle if valid |
| cfg_lower | input | ADDR_W | Lowest word address of the window |
| cfg_upper | input | ADDR_W | Highest word address of the window |
| cfg_start | input | ADDR_W | First address, inside the window |
| cfg_incr | input | ADDR_W | Signed stride in words |
| cfg_count | input | CNT_W | Number of transfers |
| cfg_fifo | input | 3 | FIFO selector |
| cfg_write | input | 1 | Direction: 1 writes memory |
| mem_valid | output | 1 | Address offered to memory |
| mem_ready | input | 1 | Memory accepts the offered address |
| mem_addr | output | ADDR_W | Current word address |
| mem_fifo | output | 3 | FIFO selector for this access |
| mem_write | output | 1 | Direction for this access |
| done | output | 1 | One-cycle pulse when the stream ends |

## Verification
The address sequence is compared against a modular model for several kinds of stride:
- A unit stride, which only wraps at the top edge.
- A stride that is smaller than the window but does not divide it, which tests the carry of the excess.
- A stride several times the window size, which tests that the stride is reduced and not merely wrapped once.
- Negative strides, both short and beyond the window, which separate a downward fold from an upward one.

Further vectors cover a one-word window, a zero stride with a count of one, and a window at the top of the address space, which exposes overflow in the address sum. Memory backpressure patterns separate a pointer that advances on acceptance from one that advances on offer. A load attempted during an active stream shows whether the description registers are protected.

// File: rtl/ring_agen_pkg.sv
package ring_agen_pkg;

    localparam int FIFO_COUNT = 8;
    localparam int FIFO_SEL_W = $clog2(FIFO_COUNT);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } agen_state_e;

    typedef struct packed {
        logic [FIFO_SEL_W-1:0] fifo;
        logic                  wr;
    } route_t;

endpackage

// File: rtl/stride_reducer.sv
module stride_reducer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] incr,
    input  logic [W:0]   win_n,
    output logic         vld,
    output logic [W-1:0] step
);
    localparam int IW = $clog2(W + 1);

    logic [W-1:0]  mag_q;
    logic          neg_q;
    logic [W-1:0]  rem_q;
    logic [IW-1:0] cnt_q;
    logic          busy_q;
    logic [W:0]    shifted;
    logic [W:0]    trial;
    logic [W:0]    pos_step;

    assign shifted = {rem_q, mag_q[W-1]};
    assign trial   = shifted - win_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_q  <= '0;
            neg_q  <= 1'b0;
            rem_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            vld    <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (start) begin
                mag_q  <= incr[W-1] ? (~incr + 1'b1) : incr;
                neg_q  <= incr[W-1];
                rem_q  <= '0;
                cnt_q  <= IW'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                mag_q <= mag_q << 1;
                rem_q <= (shifted >= win_n) ? W'(trial) : W'(shifted);
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == IW'(1)) begin
                    busy_q <= 1'b0;
                    vld    <= 1'b1;
                end
            end
        end
    end

    // A negative stride becomes the complementary positive step.
    assign pos_step = (neg_q && rem_q != '0) ? (win_n - {1'b0, rem_q}) : {1'b0, rem_q};
    assign step     = W'(pos_step);

    assert_step_in_window_R4: assert property (@(posedge clk) disable iff (rst)
        vld |-> ({1'b0, rem_q} < win_n));

endmodule

// File: rtl/ring_pointer.sv
module ring_pointer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] lower,
    input  logic [W-1:0] upper,
    input  logic [W-1:0] start,
    input  logic         step_load,
    input  logic [W-1:0] step_in,
    input  logic         adv,
    output logic [W-1:0] addr,
    output logic [W:0]   win_n
);
    logic [W-1:0] lower_q;
    logic [W:0]   n_q;
    logic [W-1:0] off_q;
    logic [W-1:0] step_q;
    logic [W:0]   sum;
    logic [W:0]   folded;

    assign sum    = {1'b0, off_q} + {1'b0, step_q};
    assign folded = (sum >= n_q) ? (sum - n_q) : sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            lower_q <= '0;
            n_q     <= '0;
            off_q   <= '0;
            step_q  <= '0;
        end else begin
            if (load) begin
                lower_q <= lower;
                n_q     <= {1'b0, upper} - {1'b0, lower} + 1'b1;
                off_q   <= start - lower;
            end else if (adv) begin
                off_q <= W'(folded);
            end
            if (step_load) step_q <= step_in;
        end
    end

    assign addr  = lower_q + off_q;
    assign win_n = n_q;

    assert_offset_in_window_R4: assert property (@(posedge clk) disable iff (rst)
        adv |=> ({1'b0, off_q} < n_q));

endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] count,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= count;
        end else if (dec) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign last = (left_q == CW'(1));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        dec |-> (left_q != '0));

endmodule

// File: rtl/ring_stream_agen.sv
module ring_stream_agen
    import ring_agen_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_valid,
    output logic                  cfg_ready,
    input  logic [ADDR_W-1:0]     cfg_lower,
    input  logic [ADDR_W-1:0]     cfg_upper,
    input  logic [ADDR_W-1:0]     cfg_start,
    input  logic [ADDR_W-1:0]     cfg_incr,
    input  logic [CNT_W-1:0]      cfg_count,
    input  logic [FIFO_SEL_W-1:0] cfg_fifo,
    input  logic                  cfg_write,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [FIFO_SEL_W-1:0] mem_fifo,
    output logic                  mem_write,
    output logic                  done
);
    agen_state_e       state_q, state_d;
    route_t            route_q;
    logic [ADDR_W-1:0] lo_q, hi_q, st_q;
    logic              cfg_fire, mem_fire, red_vld, last;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W:0]   win_n;

    assign cfg_fire = cfg_valid && (state_q == ST_IDLE);
    assign mem_fire = mem_valid && mem_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cfg_fire) state_d = (cfg_count == '0) ? ST_DONE : ST_PREP;
            ST_PREP: if (red_vld) state_d = ST_RUN;
            ST_RUN:  if (mem_fire && last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            route_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            st_q    <= '0;
        end else begin
            state_q <= state_d;
            if (cfg_fire) begin
                route_q <= '{fifo: cfg_fifo, wr: cfg_write};
                lo_q    <= cfg_lower;
                hi_q    <= cfg_upper;
                st_q    <= cfg_start;
            end
        end
    end

    stride_reducer #(.W(ADDR_W)) u_reduce (
        .clk   (clk),
        .rst   (rst),
        .start (cfg_fire),
        .incr  (cfg_incr),
        .win_n (win_n),
        .vld   (red_vld),
        .step  (step)
    );

    ring_pointer #(.W(ADDR_W)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .load      (cfg_fire),
        .lower     (cfg_lower),
        .upper     (cfg_upper),
        .start     (cfg_start),
        .step_load (red_vld),
        .step_in   (step),
        .adv       (mem_fire),
        .addr      (mem_addr),
        .win_n     (win_n)
    );

    xfer_counter #(.CW(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .load  (cfg_fire),
        .count (cfg_count),
        .dec   (mem_fire),
        .last  (last)
    );

    assign cfg_ready = (state_q == ST_IDLE);
    assign mem_valid = (state_q == ST_RUN);
    assign done      = (state_q == ST_DONE);
    assign mem_fifo  = route_q.fifo;
    assign mem_write = route_q.wr;

    assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_fifo) && $stable(mem_write)));

    assert_addr_in_window_R4: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr >= lo_q && mem_addr <= hi_q));

    assert_first_is_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_valid) |-> (mem_addr == st_q));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_zero_count_done_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_fire && cfg_count == '0) |=> (done && !mem_valid));

endmodule

// File: tb/ring_stream_agen_test.sv
module ring_stream_agen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    typedef struct packed {
        logic [15:0] lo;
        logic [15:0] hi;
        logic [15:0] st;
        logic [15:0] inc;
        logic [7:0]  cnt;
        logic [2:0]  fifo;
        logic        wr;
    } vec_t;

    // lower, upper, start, stride, count, fifo, write
    localparam vec_t VECS [NV] = '{
        '{16'd100,   16'd109,   16'd100,   16'h0001, 8'd12, 3'd0, 1'b0}, // unit stride wrap
        '{16'd100,   16'd109,   16'd105,   16'h0003, 8'd10, 3'd1, 1'b1}, // non-dividing stride
        '{16'd200,   16'd206,   16'd203,   16'd25,   8'd9,  3'd2, 1'b0}, // stride > window
        '{16'd50,    16'd59,    16'd52,    16'hFFFD, 8'd8,  3'd3, 1'b1}, // -3
        '{16'd0,     16'd15,    16'd0,     16'hFFEF, 8'd6,  3'd4, 1'b0}, // -17
        '{16'd1000,  16'd1000,  16'd1000,  16'h0005, 8'd3,  3'd5, 1'b1}, // one-word window
        '{16'd300,   16'd399,   16'd350,   16'h0000, 8'd1,  3'd6, 1'b0}, // single access
        '{16'hFFF0,  16'hFFFF,  16'hFFFE,  16'h0003, 8'd7,  3'd7, 1'b1}  // top of space
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_valid;
    logic        cfg_ready;
    logic [15:0] cfg_lower, cfg_upper, cfg_start, cfg_incr, cfg_count;
    logic [2:0]  cfg_fifo;
    logic        cfg_write;
    logic        mem_valid;
    logic        mem_ready;
    logic [15:0] mem_addr;
    logic [2:0]  mem_fifo;
    logic        mem_write;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ring_stream_agen uut (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
        .cfg_lower(cfg_lower), .cfg_upper(cfg_upper), .cfg_start(cfg_start),
        .cfg_incr(cfg_incr), .cfg_count(cfg_count),
        .cfg_fifo(cfg_fifo), .cfg_write(cfg_write),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_fifo(mem_fifo), .mem_write(mem_write), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int wrapmod(input int a, input int n);
        int r = a % n;
        if (r < 0) r += n;
        return r;
    endfunction

    task automatic run_stream(input vec_t v, input bit poke, input int stall);
        int n, off, inc, idx, guard;
        logic [15:0] prev;
        bit held;
        string tag;
        @(negedge clk);
        while (!cfg_ready) @(negedge clk);
        cfg_lower = v.lo; cfg_upper = v.hi; cfg_start = v.st;
        cfg_incr = v.inc; cfg_count = {8'd0, v.cnt};
        cfg_fifo = v.fifo; cfg_write = v.wr; cfg_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            // R1: a competing description held while the stream runs
            cfg_lower = 16'd0; cfg_upper = 16'hFFFF; cfg_start = 16'd5;
            cfg_incr = 16'd1; cfg_count = 16'd200; cfg_fifo = ~v.fifo; cfg_write = ~v.wr;
        end else begin
            cfg_valid = 1'b0;
        end
        check(cfg_ready == 1'b0, "R1", "cfg_ready after load", int'(cfg_ready), 0);
        n   = int'(v.hi) - int'(v.lo) + 1;
        off = int'(v.st) - int'(v.lo);
        inc = int'($signed(v.inc));
        tag = (inc < 0) ? "R5" : "R4";
        idx = 0; guard = 0; held = 1'b0; prev = '0;
        while (!done) begin
            guard++;
            if (guard > 2000) begin
                check(1'b0, "R3", "stream never ended", idx, int'(v.cnt));
                break;
            end
            if (poke && mem_valid)
                check(cfg_ready == 1'b0, "R1", "cfg_ready while busy", int'(cfg_ready), 0);
            if (held)
                check(mem_addr == prev && mem_valid, "R8", "address held under stall",
                      int'(mem_addr), int'(prev));
            mem_ready = (stall == 0) || (guard % stall != 0);
            if (mem_valid) begin
                if (mem_ready) begin
                    check(int'(mem_addr) == int'(v.lo) + off, (idx == 0) ? "R2" : tag,
                          "address", int'(mem_addr), int'(v.lo) + off);
                    check(mem_fifo == v.fifo && mem_write == v.wr, "R7", "fifo/dir",
                          int'({mem_fifo, mem_write}), int'({v.fifo, v.wr}));
                    idx++;
                    off = wrapmod(off + inc, n);
                    held = 1'b0;
                end else begin
                    held = 1'b1;
                    prev = mem_addr;
                end
            end else begin
                held = 1'b0;
            end
            @(negedge clk);
        end
        cfg_valid = 1'b0;
        mem_ready = 1'b0;
        check(idx == int'(v.cnt), "R3", "transfer count", idx, int'(v.cnt));
        @(negedge clk);
        check(done == 1'b0, "R3", "done lasts one cycle", int'(done), 0);
    endtask

    initial begin
        rst = 1'b1; cfg_valid = 1'b0; mem_ready = 1'b0;
        cfg_lower = '0; cfg_upper = '0; cfg_start = '0; cfg_incr = '0;
        cfg_count = '0; cfg_fifo = '0; cfg_write = 1'b0;
        repeat (3) @(negedge clk);
        check(cfg_ready == 1'b1, "R9", "cfg_ready in reset", int'(cfg_ready), 1);
        check(mem_valid == 1'b0, "R9", "mem_valid in reset", int'(mem_valid), 0);
        check(done == 1'b0, "R9", "done in reset", int'(done), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            run_stream(VECS[i], (i == 2), (i == 0) ? 0 : (i % 3) + 2);

        // R6: zero count finishes at once, without any access
        @(negedge clk);
        cfg_lower = 16'd10; cfg_upper = 16'd20; cfg_start = 16'd12;
        cfg_incr = 16'd1; cfg_count = 16'd0; cfg_valid = 1'b1; mem_ready = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
        check(done == 1'b1, "R6", "done after zero count", int'(done), 1);
        check(mem_valid == 1'b0, "R6", "no access for zero count", int'(mem_valid), 0);
        @(negedge clk);
        check(done == 1'b0 && mem_valid == 1'b0, "R6", "quiet after zero count",
              int'({done, mem_valid}), 0);
        check(cfg_ready == 1'b1, "R6", "idle after zero count", int'(cfg_ready), 1);
        mem_ready = 1'b0;

        // R9: reset in the middle of a stream
        run_stream(VECS[1], 1'b0, 0);
        @(negedge clk);
        cfg_lower = 16'd0; cfg_upper = 16'd63; cfg_start = 16'd0; cfg_incr = 16'd1;
        cfg_count = 16'd50; cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
        repeat (25) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(cfg_ready == 1'b1 && mem_valid == 1'b0 && done == 1'b0, "R9",
              "state after mid-stream reset", int'({cfg_ready, mem_valid, done}), 4);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule